// File: doc/BRIEF.md
# Burst-Mode Coarse Frequency Acquisition Loop

This block is the coarse frequency loop of a duty-cycled all-digital PLL. It runs on the reference clock. A sequencer turns the oscillator on for one reference cycle in every ten, so the oscillator runs only in short bursts. Just before each burst it issues a clear to an edge counter that runs on the oscillator output. During the burst that counter records rising oscillator edges.

When the burst is over the oscillator is stopped and the counter no longer moves. The block then takes the count into the reference domain through two flops and compares it with a frequency control word. It scales the error by a selectable right shift and adds the result to a saturating 7-bit accumulator. The accumulator is the coarse DAC code. A new code appears a few cycles after the burst and is in force for the next burst. Between updates the code is held frozen.

A count equal to the control word, or one above it, counts as zero error. This absorbs the one-edge quantization of a single-cycle measurement. After three such bursts in a row the block raises a coarse-lock flag.

Top module: `burst_coarse_loop`

## Requirements
- R1: `oscEn` is high for exactly one reference cycle in every ten. The first burst is the first cycle after reset is released.
- R2: `cntClr` is high for exactly the one cycle that comes just before each burst cycle.
- R3: The count used is the value that `edgeCount` holds in the cycle after the burst. The new `dacCode` appears at the clock edge that ends the fourth cycle counted from the burst cycle. The code seen during the three cycles after the burst is still the old one.
- R4: The raw error is `fcw` minus the count, taken as a signed value. It is forced to zero when the count equals `fcw` or equals `fcw`+1.
- R5: The error is shifted arithmetically right by `gainSel` bits (0 to 3), so it rounds toward minus infinity. For example, -2 with a shift of 2 gives -1.
- R6: The scaled error is added to `dacCode`. The sum saturates at 0 and at 127 and never wraps.
- R7: Between updates, `dacCode` and `coarseLock` do not change, whatever `edgeCount`, `fcw` and `gainSel` do.
- R8: `coarseLock` goes high at the update that completes three consecutive zero-error updates. It goes low at the first update with a nonzero error.
- R9: Reset is asynchronous and active low. It sets `dacCode` to 64 and `coarseLock` to 0, and restarts the sequence at the burst cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fcw | input | 8 | Frequency control word: expected edges per burst |
| gainSel | input | 2 | Loop-gain right-shift amount |
| edgeCount | input | 8 | Edge count from the oscillator-domain counter |
| oscEn | output | 1 | Oscillator enable, high during the burst cycle |
| cntClr | output | 1 | Clear for the edge counter, high in the cycle before a burst |
| dacCode | output | 7 | Coarse DAC code |
| coarseLock | output | 1 | Coarse-lock indication |

## Verification
Two events fall on the same clock edge: the accumulator update and the lock-run decision. The same edge also clears the lock when the error is nonzero. The vectors provoke this with a zero-error burst that completes the third run, followed at once by a burst that is off by two. Both the code and the flag are judged in the cycle after that shared edge. Saturation is provoked in the same way, with errors large enough to push the sum past both rails. Garbage is driven on every input between bursts, which shows that the hold holds.

// File: rtl/burst_coarse_pkg.sv
package burst_coarse_pkg;
  typedef struct packed {
    logic oscEn;
    logic cntClr;
    logic update;
  } seqStrobes_t;
endpackage

// File: rtl/burst_seq.sv
module burst_seq
  import burst_coarse_pkg::*;
#(
  parameter int PERIOD        = 10,
  parameter int CAPTURE_PHASE = 3
) (
  input  logic        clk,
  input  logic        rstN,
  output seqStrobes_t strb
);
  localparam int PH_W = $clog2(PERIOD);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PERIOD - 1);
  localparam logic [PH_W-1:0] CAP_PH  = PH_W'(CAPTURE_PHASE);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                phase <= '0;
    else if (phase == LAST_PH) phase <= '0;
    else                      phase <= phase + 1'b1;
  end

  always_comb begin
    strb.oscEn  = (phase == '0);
    strb.cntClr = (phase == LAST_PH);
    strb.update = (phase == CAP_PH);
  end

  p_burst_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.oscEn |=> !strb.oscEn);
  p_clr_before_burst_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntClr |=> strb.oscEn);
  p_update_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.update |-> (!strb.oscEn && !strb.cntClr));
endmodule

// File: rtl/burst_coarse_dp.sv
module burst_coarse_dp
  import burst_coarse_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int CODE_W    = 7,
  parameter int INIT_CODE = 64,
  parameter int LOCK_RUNS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strb,
  input  logic [CNT_W-1:0]  fcw,
  input  logic [1:0]        gainSel,
  input  logic [CNT_W-1:0]  edgeCount,
  output logic [CODE_W-1:0] dacCode,
  output logic              coarseLock
);
  localparam int ERR_W  = CNT_W + 1;
  localparam int SUM_W  = ((ERR_W > CODE_W + 1) ? ERR_W : CODE_W + 1) + 1;
  localparam int RUN_W  = $clog2(LOCK_RUNS + 1);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [RUN_W-1:0]  RUN_DONE = RUN_W'(LOCK_RUNS);

  logic [CNT_W-1:0]        syncA, syncB;
  logic [CODE_W-1:0]       codeQ;
  logic [RUN_W-1:0]        runCnt;
  logic                    lockQ;
  logic signed [ERR_W-1:0] errRaw, errEff, errScaled;
  logic signed [SUM_W-1:0] sumExt;
  logic                    zeroErr;
  logic [CODE_W-1:0]       codeNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= edgeCount;
      syncB <= syncA;
    end
  end

  always_comb begin
    errRaw    = $signed({1'b0, fcw}) - $signed({1'b0, syncB});
    zeroErr   = ({1'b0, syncB} == {1'b0, fcw}) ||
                ({1'b0, syncB} == ({1'b0, fcw} + 1'b1));
    errEff    = zeroErr ? '0 : errRaw;
    errScaled = errEff >>> gainSel;
    sumExt    = $signed({{(SUM_W-CODE_W){1'b0}}, codeQ}) +
                $signed({{(SUM_W-ERR_W){errScaled[ERR_W-1]}}, errScaled});
    if (sumExt < 0)
      codeNext = '0;
    else if (sumExt > $signed({{(SUM_W-CODE_W){1'b0}}, CODE_MAX}))
      codeNext = CODE_MAX;
    else
      codeNext = sumExt[CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ  <= CODE_W'(INIT_CODE);
      runCnt <= '0;
      lockQ  <= 1'b0;
    end else if (strb.update) begin
      codeQ <= codeNext;
      if (!zeroErr) begin
        runCnt <= '0;
        lockQ  <= 1'b0;
      end else if (runCnt != RUN_DONE) begin
        runCnt <= runCnt + 1'b1;
        lockQ  <= (runCnt + 1'b1) == RUN_DONE;
      end
    end
  end

  assign dacCode    = codeQ;
  assign coarseLock = lockQ;

  p_hold_code_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.update |=> ($stable(codeQ) && $stable(lockQ)));
  p_exact_no_move_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.update && syncB == fcw) |=> $stable(codeQ));
  p_slow_rises_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.update && syncB < fcw) |=> (codeQ >= $past(codeQ)));
  p_lock_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.update && ({1'b0, syncB} > ({1'b0, fcw} + 1'b1))) |=> !lockQ);
endmodule

// File: rtl/burst_coarse_loop.sv
module burst_coarse_loop
  import burst_coarse_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int CODE_W        = 7,
  parameter int PERIOD        = 10,
  parameter int CAPTURE_PHASE = 3,
  parameter int INIT_CODE     = 64,
  parameter int LOCK_RUNS     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  fcw,
  input  logic [1:0]        gainSel,
  input  logic [CNT_W-1:0]  edgeCount,
  output logic              oscEn,
  output logic              cntClr,
  output logic [CODE_W-1:0] dacCode,
  output logic              coarseLock
);
  seqStrobes_t strb;

  burst_seq #(.PERIOD(PERIOD), .CAPTURE_PHASE(CAPTURE_PHASE)) u_seq (
    .clk(clk), .rstN(rstN), .strb(strb)
  );

  burst_coarse_dp #(.CNT_W(CNT_W), .CODE_W(CODE_W), .INIT_CODE(INIT_CODE),
                    .LOCK_RUNS(LOCK_RUNS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fcw(fcw), .gainSel(gainSel),
    .edgeCount(edgeCount), .dacCode(dacCode), .coarseLock(coarseLock)
  );

  assign oscEn  = strb.oscEn;
  assign cntClr = strb.cntClr;
endmodule

// File: tb/tb_burst_coarse_loop.sv
module tb_burst_coarse_loop;
  localparam int CLK_PERIOD = 10;
  localparam int VEC_N = 14;
  localparam int V_FCW [VEC_N] = '{100, 100, 100, 100, 100, 100, 100, 200, 200,   5, 5, 50, 50, 50};
  localparam int V_GAIN[VEC_N] = '{  0,   1,   0,   0,   3,   0,   0,   0,   0,   0, 2,  2,  3,  1};
  localparam int V_CNT [VEC_N] = '{ 90,  80, 101, 100, 100, 102,  99,  10,   0, 255, 7, 10, 30, 53};
  localparam int V_CODE[VEC_N] = '{ 74,  84,  84,  84,  84,  82,  83, 127, 127,   0, 0, 10, 12, 10};
  localparam int V_LOCK[VEC_N] = '{  0,   0,   0,   0,   1,   0,   0,   0,   0,   0, 0,  0,  0,  0};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] fcw = '0;
  logic [1:0] gainSel = '0;
  logic [7:0] edgeCount = '0;
  logic       oscEn, cntClr, coarseLock;
  logic [6:0] dacCode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_coarse_loop dut (
    .clk(clk), .rstN(rstN), .fcw(fcw), .gainSel(gainSel), .edgeCount(edgeCount),
    .oscEn(oscEn), .cntClr(cntClr), .dacCode(dacCode), .coarseLock(coarseLock)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Entered just after a negedge in the burst cycle; leaves at the next burst cycle.
  task automatic burst(input int f, input int g, input int c, input int expCode, input int expLock);
    int held;
    int heldLock;
    chk(oscEn == 1'b1, "R1 burst cycle", oscEn, 1);
    fcw = 8'(f); gainSel = 2'(g); edgeCount = 8'(c);
    held = dacCode; heldLock = coarseLock;
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      chk(oscEn == 1'b0, "R1 idle", oscEn, 0);
      chk(dacCode == held, "R3 old code before update", dacCode, held);
      chk(coarseLock == heldLock, "R7 lock before update", coarseLock, heldLock);
    end
    @(negedge clk);
    chk(dacCode == expCode, "R6 updated code", dacCode, expCode);
    chk(coarseLock == expLock, "R8 lock after update", coarseLock, expLock);
    fcw = 8'hA5; gainSel = 2'd3; edgeCount = 8'h3C;
    for (int i = 5; i <= 9; i++) begin
      @(negedge clk);
      if (i == 7) begin fcw = 8'h00; edgeCount = 8'hFF; gainSel = 2'd0; end
      chk(dacCode == expCode, "R7 code held", dacCode, expCode);
      chk(coarseLock == expLock, "R7 lock held", coarseLock, expLock);
      chk(cntClr == (i == 9), "R2 clear timing", cntClr, (i == 9));
      chk(oscEn == 1'b0, "R1 idle", oscEn, 0);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(dacCode == 7'd64, "R9 reset code", dacCode, 64);
    chk(coarseLock == 1'b0, "R9 reset lock", coarseLock, 0);
    rstN = 1'b1;
    for (int v = 0; v < VEC_N; v++)
      burst(V_FCW[v], V_GAIN[v], V_CNT[v], V_CODE[v], V_LOCK[v]);

    // R9: reset in mid-run
    repeat (2) @(negedge clk);
    rstN = 1'b0;
    #1;
    chk(dacCode == 7'd64, "R9 mid-run reset code", dacCode, 64);
    chk(coarseLock == 1'b0, "R9 mid-run reset lock", coarseLock, 0);
    chk(oscEn == 1'b1, "R9 sequence restart", oscEn, 1);
    @(negedge clk);
    rstN = 1'b1;
    // R4 and R8: three zero-error bursts (count equals fcw or fcw+1) after reset
    burst(60, 0, 60, 64, 0);
    burst(60, 2, 61, 64, 0);
    burst(60, 1, 60, 64, 1);
    // R5: negative rounding with the largest shift, lock clears on the same edge
    burst(60, 3, 63, 63, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule